// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block collects level-sensitive interrupt requests from a group of peripherals and presents a single request line to the processor, together with a vector number that identifies the winning source. Each source has its own priority that software programs. The processor runs at a current priority level. A request reaches the processor only when its priority is strictly greater than that level, so a handler can be preempted only by a more urgent one.

The processor acknowledges an interrupt in one of two ways: a hardware strobe, or a read of the acknowledge register on the register bus. Either one returns the vector, saves the old current priority on a hardware last-in-first-out stack, and raises the current priority to the level being serviced. A write to the end-of-interrupt register pops the saved level back. Software may also write the current priority directly, which raises the level around a shared resource (priority ceiling) and lowers it afterwards.

Requests pass through three register stages: input capture, arbitration and masking. A non-maskable input is passed straight to its output without any processing.

Top module: `pirq_ctrl`

## Requirements
- R1: With a source's priority above the current priority, `irq_out` is low after the second rising edge that follows the assertion of that source's request and is high after the third.
- R2: `irq_out` is asserted only when the winning pending priority is strictly greater than the current priority. A source with priority 0 never interrupts.
- R3: Among pending sources, the highest priority wins, and on a tie the lowest-numbered source wins. `irq_vec` carries the source index, zero-extended to 9 bits.
- R4: An acknowledge taken while `irq_out` is high does all of the following: it returns bit 9 = 1 with the vector in bits 8:0, pushes the old current priority, loads the serviced priority into the current priority, and drives `irq_out` low after the same edge. The acknowledge is either a `hw_ack` pulse or a bus read of address 0x01, whose data appears on `bus_rdata` one cycle later.
- R5: An acknowledge while `irq_out` is low returns 0x01FF. It leaves the current priority and the stack depth unchanged.
- R6: A bus write to address 0x02 (end of interrupt) pops the top of the stack into the current priority. If the stack is empty, nothing changes.
- R7: The current priority is read and written at address 0x00 in bits 3:0. Reads return their data on the cycle after the request.
- R8: The status register at address 0x03 holds a sticky overflow flag in bit 0 and the stack depth in bits 7:4. A push onto a full stack (15 entries) is discarded and sets the flag. Any write to 0x03 clears the flag.
- R9: The priority of source i is read and written at address 0x20+i in bits 3:0. Higher bits of the written data are dropped.
- R10: `nmi_out` follows `nmi_in` with no register stage.
- R11: If `hw_ack` coincides with a bus write to 0x00 or 0x02, the acknowledge is processed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | N_SRC | Level-sensitive peripheral requests |
| nmi_in | input | 1 | Non-maskable request input |
| nmi_out | output | 1 | Non-maskable request, passed through |
| irq_out | output | 1 | Registered interrupt request to the processor |
| irq_vec | output | 9 | Vector of the pending interrupt |
| hw_ack | input | 1 | Hardware acknowledge strobe from the processor |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after the read |

## Verification
The embedded properties check relations that must hold on every cycle:
- a raised request always exceeds the masking level in force when it was formed;
- the arbitration winner was actually requested;
- an acknowledge loads the serviced level and clears the request;
- an end of interrupt restores the stacked level;
- a full stack keeps its depth, and the overflow flag stays set until cleared.

Only the bench scenarios can show the exact three-cycle request latency, the tie-break order across every pair of sources, and the full 0-to-15 sweep of the masking threshold. The same holds for the contents of the stack, popped back in reverse order after an overflow.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int VEC_W     = 9;
  localparam int ADR_CUR   = 'h00;
  localparam int ADR_ACK   = 'h01;
  localparam int ADR_EOI   = 'h02;
  localparam int ADR_STAT  = 'h03;
  localparam int ADR_PRIO0 = 'h20;
  localparam logic [VEC_W-1:0] SPURIOUS_VEC = '1;
endpackage

// File: rtl/pirq_req_stage.sv
module pirq_req_stage #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_in,
  output logic [N_SRC-1:0] src_q
);
  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_in;
  end
endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_SRC-1:0]        req,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic                    win_valid,
  output logic [PRIO_W-1:0]       win_prio,
  output logic [IDX_W-1:0]        win_id
);
  logic [PRIO_W-1:0] best_p;
  logic [IDX_W-1:0]  best_i;

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    best_p = '0;
    best_i = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i] && (prio_flat[i*PRIO_W +: PRIO_W] != '0) &&
          (prio_flat[i*PRIO_W +: PRIO_W] >= best_p)) begin
        best_p = prio_flat[i*PRIO_W +: PRIO_W];
        best_i = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_prio  <= '0;
      win_id    <= '0;
    end else begin
      win_valid <= (best_p != '0);
      win_prio  <= best_p;
      win_id    <= best_i;
    end
  end

  assert_winner_requested_R3: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> ((($past(req) >> win_id) & N_SRC'(1)) != '0));
endmodule

// File: rtl/pirq_lifo.sv
module pirq_lifo #(
  parameter int DEPTH = 15,
  parameter int W     = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] top_ptr;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign top_ptr = count - 1'b1;
  assign dout    = empty ? '0 : mem[top_ptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[count] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)                   count <= '0;
    else if (push && !full)    count <= count + 1'b1;
    else if (pop && !empty)    count <= count - 1'b1;
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (count == $past(count)));
  assert_pop_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int N_SRC      = 8,
  parameter int PRIO_W     = 4,
  parameter int LIFO_DEPTH = 15,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_src,
  input  logic              nmi_in,
  output logic              nmi_out,
  output logic              irq_out,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              hw_ack,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int CNT_W = $clog2(LIFO_DEPTH + 1);

  logic [N_SRC-1:0]        req_q;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic                    win_valid;
  logic [PRIO_W-1:0]       win_prio;
  logic [IDX_W-1:0]        win_id;
  logic [PRIO_W-1:0]       cur_q, lifo_dout, irq_prio_q, prio_rd;
  logic [CNT_W-1:0]        lifo_cnt;
  logic                    lifo_full, lifo_empty;
  logic                    irq_q, ovf_q;
  logic [VEC_W-1:0]        vec_q;
  logic                    rd_en, wr_en, ack_any, ack_take;
  logic                    eoi_do, pop_do, cur_wr, stat_wr;
  logic                    unused_wdata_hi;

  assign nmi_out = nmi_in;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:PRIO_W];

  pirq_req_stage #(.N_SRC(N_SRC)) u_stage (
    .clk(clk), .rst(rst), .src_in(irq_src), .src_q(req_q)
  );

  pirq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst(rst), .req(req_q), .prio_flat(prio_flat),
    .win_valid(win_valid), .win_prio(win_prio), .win_id(win_id)
  );

  // Bus decode; an acknowledge outranks register writes in the same cycle.
  assign rd_en    = bus_sel && !bus_wr;
  assign wr_en    = bus_sel &&  bus_wr;
  assign ack_any  = hw_ack || (rd_en && bus_addr == ADDR_W'(ADR_ACK));
  assign ack_take = ack_any && irq_q;
  assign eoi_do   = wr_en && bus_addr == ADDR_W'(ADR_EOI) && !ack_any;
  assign pop_do   = eoi_do && !lifo_empty;
  assign cur_wr   = wr_en && bus_addr == ADDR_W'(ADR_CUR) && !ack_any;
  assign stat_wr  = wr_en && bus_addr == ADDR_W'(ADR_STAT);

  pirq_lifo #(.DEPTH(LIFO_DEPTH), .W(PRIO_W)) u_lifo (
    .clk(clk), .rst(rst), .push(ack_take), .pop(pop_do), .din(cur_q),
    .dout(lifo_dout), .count(lifo_cnt), .full(lifo_full), .empty(lifo_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) prio_flat <= '0;
    else if (wr_en) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (bus_addr == ADDR_W'(ADR_PRIO0 + i))
          prio_flat[i*PRIO_W +: PRIO_W] <= bus_wdata[PRIO_W-1:0];
      end
    end
  end

  always_comb begin
    prio_rd = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (bus_addr == ADDR_W'(ADR_PRIO0 + i)) prio_rd = prio_flat[i*PRIO_W +: PRIO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           cur_q <= '0;
    else if (ack_take) cur_q <= irq_prio_q;
    else if (pop_do)   cur_q <= lifo_dout;
    else if (cur_wr)   cur_q <= bus_wdata[PRIO_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                       ovf_q <= 1'b0;
    else if (ack_take && lifo_full) ovf_q <= 1'b1;
    else if (stat_wr)              ovf_q <= 1'b0;
  end

  // Mask stage: third register from the request pins.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q      <= 1'b0;
      vec_q      <= '0;
      irq_prio_q <= '0;
    end else begin
      irq_q      <= !ack_take && win_valid && (win_prio > cur_q);
      vec_q      <= VEC_W'(win_id);
      irq_prio_q <= win_prio;
    end
  end

  assign irq_out = irq_q;
  assign irq_vec = vec_q;

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_en) begin
      unique case (int'(bus_addr))
        ADR_CUR:  bus_rdata <= DATA_W'(cur_q);
        ADR_ACK:  bus_rdata <= ack_take ? DATA_W'({1'b1, vec_q}) : DATA_W'(SPURIOUS_VEC);
        ADR_STAT: bus_rdata <= DATA_W'({lifo_cnt, 3'b000, ovf_q});
        default:  bus_rdata <= DATA_W'(prio_rd);
      endcase
    end
  end

  assert_irq_above_mask_R2: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (irq_prio_q > $past(cur_q)));
  assert_vec_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (vec_q < VEC_W'(N_SRC)));
  assert_ack_loads_level_R4: assert property (@(posedge clk) disable iff (rst)
    ack_take |=> (cur_q == $past(irq_prio_q)) && !irq_q);
  assert_eoi_restores_R6: assert property (@(posedge clk) disable iff (rst)
    pop_do |=> (cur_q == $past(lifo_dout)));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !stat_wr) |=> ovf_q);
endmodule

// File: tb/pirq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pirq_ctrl_tb_top;
  localparam int N  = 8;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_src = '0;
  logic nmi_in = 1'b0, nmi_out, irq_out, hw_ack = 1'b0;
  logic [8:0] irq_vec;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pirq_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_src(irq_src), .nmi_in(nmi_in), .nmi_out(nmi_out),
    .irq_out(irq_out), .irq_vec(irq_vec), .hw_ack(hw_ack), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    bus_sel = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);
    chk("R2 reset irq", int'(irq_out), 0);
    rd('h00, d); chk("R7 reset cur", d, 0);
    rd('h03, d); chk("R8 reset status", d, 0);

    // R10 pass-through
    nmi_in = 1'b1; #1 chk("R10 nmi high", int'(nmi_out), 1);
    nmi_in = 1'b0; #1 chk("R10 nmi low", int'(nmi_out), 0);

    // R9 priority readback with upper bits dropped
    for (int i = 0; i < N; i++) wr('h20 + i, 'hFFF0 | ((i * 5 + 3) % 16));
    for (int i = 0; i < N; i++) begin
      rd('h20 + i, d); chk("R9 prio readback", d, (i * 5 + 3) % 16);
    end
    // R7 current priority readback
    wr('h00, 'hAB9); rd('h00, d); chk("R7 cur readback", d, 9);
    wr('h00, 0);

    // R1/R2 sweep: every source, level and priority
    for (int s = 0; s < N; s++) begin
      for (int c = 0; c < 16; c++) begin
        for (int p = 0; p < 16; p++) begin
          wr('h20 + s, p);
          wr('h00, c);
          idle(1);
          irq_src[s] = 1'b1;
          idle(2);
          chk("R1 no early irq", int'(irq_out), 0);
          idle(1);
          chk("R2 masking", int'(irq_out), (p > c) ? 1 : 0);
          if (p > c) chk("R3 vector", int'(irq_vec), s);
          irq_src[s] = 1'b0;
          idle(4);
        end
      end
      wr('h20 + s, 0);
    end
    wr('h00, 0);

    // R3 pairwise arbitration
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        for (int pi = 1; pi < 4; pi++) begin
          for (int pj = 1; pj < 4; pj++) begin
            wr('h20 + i, pi); wr('h20 + j, pj);
            irq_src[i] = 1'b1; irq_src[j] = 1'b1;
            idle(4);
            chk("R3 irq pair", int'(irq_out), 1);
            chk("R3 winner", int'(irq_vec), (pi >= pj) ? i : j);
            irq_src = '0;
            idle(4);
          end
        end
        wr('h20 + i, 0); wr('h20 + j, 0);
      end
    end

    // R4 nesting with bus and hardware acknowledge, R6 pops
    wr('h20, 3); wr('h21, 7);
    irq_src[0] = 1'b1; idle(4);
    rd('h01, d); chk("R4 bus ack data", d, 'h200);
    chk("R4 irq dropped", int'(irq_out), 0);
    rd('h00, d); chk("R4 cur raised", d, 3);
    irq_src[1] = 1'b1; idle(4);
    chk("R4 nested irq", int'(irq_out), 1);
    chk("R4 nested vec", int'(irq_vec), 1);
    hw_ack = 1'b1; @(negedge clk); hw_ack = 1'b0;
    chk("R4 hw ack drops irq", int'(irq_out), 0);
    rd('h00, d); chk("R4 cur after hw ack", d, 7);
    rd('h03, d); chk("R8 depth two", d, 2 << 4);
    irq_src = '0; idle(4);
    wr('h02, 0); rd('h00, d); chk("R6 pop to 3", d, 3);
    wr('h02, 0); rd('h00, d); chk("R6 pop to 0", d, 0);
    wr('h02, 0); rd('h00, d); chk("R6 pop empty", d, 0);
    rd('h03, d); chk("R6 depth zero", d, 0);

    // R11 collision: hw ack wins over a current-priority write
    irq_src[0] = 1'b1; idle(4);
    hw_ack = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'('h00); bus_wdata = DW'(12);
    @(negedge clk);
    hw_ack = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd('h00, d); chk("R11 ack beats write", d, 3);
    irq_src = '0; idle(4);
    wr('h02, 0); rd('h00, d); chk("R11 pop after", d, 0);

    // R5 spurious acknowledge
    rd('h01, d); chk("R5 spurious data", d, 'h1FF);
    rd('h00, d); chk("R5 cur unchanged", d, 0);
    rd('h03, d); chk("R5 depth unchanged", d, 0);

    // R8 overflow
    wr('h20, 15); irq_src[0] = 1'b1;
    for (int k = 0; k < 16; k++) begin
      wr('h00, (k < 15) ? k : 5);
      idle(3);
      rd('h01, d); chk("R8 ack during fill", d, 'h200);
    end
    rd('h03, d); chk("R8 full with overflow", d, (15 << 4) | 1);
    irq_src = '0; idle(4);
    for (int k = 14; k >= 0; k--) begin
      wr('h02, 0); rd('h00, d); chk("R6 pop order", d, k);
    end
    rd('h03, d); chk("R8 sticky after pops", d, 1);
    wr('h03, 0); rd('h03, d); chk("R8 cleared", d, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule